// File: doc/BRIEF.md
# Interrupting General-Purpose I/O Port

A 32-pin general-purpose port with a register interface. Each pin is an output or an input according to its direction bit. Output pins take their level from software writes: a direct write of the value register, or set-bit and clear-bit aliases of it. Input pins pass through a two-flop synchroniser. An optional per-pin inversion is applied before the level is stored in the same value register. The stored value drives `pin_out`, and the direction register drives `pin_oe`.

Any 0-to-1 change of a stored bit records a sticky cause bit. Pins are gathered in groups of eight, and each group has a summary interrupt line. The line is raised when a pin of the group rises while its mask bit is set. How the line is released depends on a mode bit:
- In level mode, the line drops once the group's stored bits have all fallen to zero.
- In edge mode, software releases it by rewriting the cause register.

The register port is a plain 32-bit word interface. Writes take effect on the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the direction, inversion, value, cause, mask and mode registers are all 0, and so are `pin_out`, `pin_oe` and `grp_irq`.
- R2: A write to the value register (word address 0x2) changes only the bits whose direction bit (address 0x0, 1 = output) is 1. `pin_out` shows the stored value and `pin_oe` shows the direction register.
- R3: The set alias (0x3) ORs the written data into output bits only. The clear alias (0x4) clears output bits where the data is 1. Reading either alias returns 0.
- R4: An input pin's stored bit equals the pin XOR its inversion bit (address 0x1). It appears in the value register on the third clock edge after the pin changes.
- R5: A 0-to-1 change of any stored bit sets the matching bit of the cause register (0x5). Cause bits stay set until software writes the cause register.
- R6: When a stored bit rises and its mask bit is 1, `grp_irq[pin/8]` goes high on the same edge that stores the bit. A rise with mask bit 0 leaves the summary unchanged.
- R7: The mode register (0x8) holds the level-mode bit at bit 10 and reads back at bit 10. Its other bits read 0. Unmapped addresses read 0 and ignore writes.
- R8: In level mode (bit 10 = 1), a summary drops when a stored bit of its group falls and all eight stored bits of the group are then 0. Cause writes do not drop it.
- R9: In edge mode, a cause write replaces the cause register. A group whose cause bits changed and are now all 0 drops its summary, and the other groups keep theirs. A hardware rise on the same edge wins over the write.
- R10: Word addresses 0x6 and 0x7 both write and read the same 32-bit mask register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS (32) | Asynchronous pin levels |
| pin_out | output | NPINS (32) | Stored value, driven to the pads |
| pin_oe | output | NPINS (32) | Output enable, one per pin (direction register) |
| reg_addr | input | ADDR_W (4) | Word address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr` |
| grp_irq | output | NPINS/GRP_W (4) | Summary interrupt per group of eight pins |

## Verification
A corrupted value register shows on `pin_out` on the very next cycle, and on reads at once. A wrong cause or mask bit stays hidden until a read, or until the next rise of that pin, which is when `grp_irq` goes wrong. Summary errors from the two release paths only appear after a fall of the group's last high pin (level mode) or after a cause write (edge mode). The bench therefore keeps a reference model of every register and checks all registers and outputs after each operation. This way a divergence is caught in the operation that caused it.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   // word offsets of the register file
   localparam int unsigned OFS_DIR     = 0;
   localparam int unsigned OFS_POL     = 1;
   localparam int unsigned OFS_VAL     = 2;
   localparam int unsigned OFS_SET     = 3;
   localparam int unsigned OFS_CLR     = 4;
   localparam int unsigned OFS_CAUSE   = 5;
   localparam int unsigned OFS_MASK_A  = 6;
   localparam int unsigned OFS_MASK_B  = 7;
   localparam int unsigned OFS_CTRL    = 8;
   localparam int unsigned MIN_ADDR_W  = 4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

   // R4: the synchroniser output is the input seen STAGES edges earlier
   p_sync_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (chain[1] == $past(chain[0])));
endmodule

// File: rtl/gpio_grp_irq.sv
module gpio_grp_irq #(
   parameter int GW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          level_mode,
   input  logic [GW-1:0] val_old,
   input  logic [GW-1:0] val_new,
   input  logic [GW-1:0] mask,
   input  logic [GW-1:0] cause_old,
   input  logic [GW-1:0] cause_new,
   input  logic          cause_wr,
   output logic          irq
);
   logic raise;
   logic drop_lvl;
   logic drop_edge;

   assign raise     = |(val_new & ~val_old & mask);
   assign drop_lvl  = level_mode && (|(val_old & ~val_new)) && !(|val_new);
   assign drop_edge = !level_mode && cause_wr && (cause_old != cause_new) && !(|cause_new);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq <= 1'b0;
      end else if (raise) begin
         irq <= 1'b1;
      end else if (drop_lvl || drop_edge) begin
         irq <= 1'b0;
      end
   end

   // R6: a masked rise always leaves the summary high
   p_masked_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      raise |=> irq);
   // R8: a cause write never releases the summary in level mode
   p_lvl_cause_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (level_mode && irq && !(|(val_old & ~val_new))) |=> irq);
   // R9: in edge mode nothing but a cause write releases the summary
   p_edge_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_mode && irq && !cause_wr) |=> irq);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
   parameter int NPINS       = 32,
   parameter int GRP_W       = 8,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int MODE_BIT    = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NPINS-1:0]         pin_in,
   output logic [NPINS-1:0]         pin_out,
   output logic [NPINS-1:0]         pin_oe,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic                     reg_wr,
   input  logic [DATA_W-1:0]        reg_wdata,
   output logic [DATA_W-1:0]        reg_rdata,
   output logic [NPINS/GRP_W-1:0]   grp_irq
);
   import gpio_port_pkg::*;

   localparam int NGRP = NPINS / GRP_W;
   localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(OFS_DIR);
   localparam logic [ADDR_W-1:0] A_POL    = ADDR_W'(OFS_POL);
   localparam logic [ADDR_W-1:0] A_VAL    = ADDR_W'(OFS_VAL);
   localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(OFS_SET);
   localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(OFS_CLR);
   localparam logic [ADDR_W-1:0] A_CAUSE  = ADDR_W'(OFS_CAUSE);
   localparam logic [ADDR_W-1:0] A_MASK_A = ADDR_W'(OFS_MASK_A);
   localparam logic [ADDR_W-1:0] A_MASK_B = ADDR_W'(OFS_MASK_B);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);

   generate
      if (NPINS % GRP_W != 0) begin : g_bad_group
         $error("gpio_irq_port: NPINS must be a multiple of GRP_W");
      end
      if (NPINS > DATA_W) begin : g_bad_width
         $error("gpio_irq_port: NPINS must not exceed DATA_W");
      end
      if (MODE_BIT >= DATA_W) begin : g_bad_mode
         $error("gpio_irq_port: MODE_BIT outside the data word");
      end
      if (ADDR_W < int'(MIN_ADDR_W)) begin : g_bad_addr
         $error("gpio_irq_port: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [NPINS-1:0] dir_q, pol_q, val_q, cause_q, mask_q;
   logic             level_q;
   logic [NPINS-1:0] pin_sync, sw_val, val_d, cause_d, rise, wd;
   logic             wr_dir, wr_pol, wr_val, wr_set, wr_clr, wr_cause, wr_mask, wr_ctrl;

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   assign wd       = reg_wdata[NPINS-1:0];
   assign wr_dir   = reg_wr && (reg_addr == A_DIR);
   assign wr_pol   = reg_wr && (reg_addr == A_POL);
   assign wr_val   = reg_wr && (reg_addr == A_VAL);
   assign wr_set   = reg_wr && (reg_addr == A_SET);
   assign wr_clr   = reg_wr && (reg_addr == A_CLR);
   assign wr_cause = reg_wr && (reg_addr == A_CAUSE);
   assign wr_mask  = reg_wr && ((reg_addr == A_MASK_A) || (reg_addr == A_MASK_B));
   assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);

   always_comb begin
      sw_val = val_q;
      if (wr_val) begin
         sw_val = wd;
      end else if (wr_set) begin
         sw_val = val_q | wd;
      end else if (wr_clr) begin
         sw_val = val_q & ~wd;
      end
   end

   assign val_d   = (dir_q & sw_val) | (~dir_q & (pin_sync ^ pol_q));
   assign rise    = val_d & ~val_q;
   assign cause_d = (wr_cause ? wd : cause_q) | rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         pol_q   <= '0;
         val_q   <= '0;
         cause_q <= '0;
         mask_q  <= '0;
         level_q <= 1'b0;
      end else begin
         val_q   <= val_d;
         cause_q <= cause_d;
         if (wr_dir)  dir_q   <= wd;
         if (wr_pol)  pol_q   <= wd;
         if (wr_mask) mask_q  <= wd;
         if (wr_ctrl) level_q <= reg_wdata[MODE_BIT];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_DIR:    reg_rdata[NPINS-1:0] = dir_q;
         A_POL:    reg_rdata[NPINS-1:0] = pol_q;
         A_VAL:    reg_rdata[NPINS-1:0] = val_q;
         A_CAUSE:  reg_rdata[NPINS-1:0] = cause_q;
         A_MASK_A: reg_rdata[NPINS-1:0] = mask_q;
         A_MASK_B: reg_rdata[NPINS-1:0] = mask_q;
         A_CTRL:   reg_rdata[MODE_BIT]  = level_q;
         default:  reg_rdata = '0;
      endcase
   end

   generate
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         gpio_grp_irq #(.GW(GRP_W)) i_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .level_mode(level_q),
            .val_old   (val_q[g*GRP_W +: GRP_W]),
            .val_new   (val_d[g*GRP_W +: GRP_W]),
            .mask      (mask_q[g*GRP_W +: GRP_W]),
            .cause_old (cause_q[g*GRP_W +: GRP_W]),
            .cause_new (cause_d[g*GRP_W +: GRP_W]),
            .cause_wr  (wr_cause),
            .irq       (grp_irq[g])
         );
      end
   endgenerate

   assign pin_out = val_q;
   assign pin_oe  = dir_q;

   // R2: output bits move only on a value-register access
   p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_val || wr_set || wr_clr || wr_dir) |=> (((val_q ^ $past(val_q)) & dir_q) == '0));
   // R3: the set and clear aliases always read as zero
   p_alias_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_addr == A_SET) || (reg_addr == A_CLR)) |-> (reg_rdata == '0));
   // R4: input bits follow the synchronised pin through the inversion
   p_input_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (((val_q ^ $past(pin_sync) ^ $past(pol_q)) & ~$past(dir_q)) == '0));
   // R5: every rise of the stored value leaves its cause bit set
   p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((val_q & ~$past(val_q) & ~cause_q) == '0));
   // R5: cause bits are sticky without a cause write
   p_cause_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cause |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
   // R7: the mode bit takes the written bit
   p_mode_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (level_q == $past(reg_wdata[MODE_BIT])));
   // R10: both mask addresses load the same register
   p_mask_alias_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask |=> (mask_q == $past(wd)));
endmodule

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  grp_irq;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   // reference model state
   logic [31:0] m_dir = '0, m_pol = '0, m_val = '0, m_cause = '0, m_mask = '0;
   logic        m_level = 1'b0;
   logic [3:0]  m_irq = '0;

   always #4 clk = ~clk;

   gpio_irq_port i_gpio_irq_port (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .grp_irq(grp_irq)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s act=0x%08h exp=0x%08h", req, what, act, exp);
      end
   endtask

   // one clock edge of the model; w marks a register write on that edge
   task automatic model_step(input bit w, input logic [3:0] a, input logic [31:0] d);
      logic [31:0] sw, nv, rise, fall, nc;
      logic [3:0]  ni;
      sw = m_val;
      if (w && a == 4'h2) sw = d;
      if (w && a == 4'h3) sw = m_val | d;
      if (w && a == 4'h4) sw = m_val & ~d;
      nv   = (m_dir & sw) | (~m_dir & (pin_in ^ m_pol));
      rise = nv & ~m_val;
      fall = m_val & ~nv;
      nc   = ((w && a == 4'h5) ? d : m_cause) | rise;
      ni   = m_irq;
      for (int g = 0; g < 4; g++) begin
         if ((rise[g*8 +: 8] & m_mask[g*8 +: 8]) != 8'h0) ni[g] = 1'b1;
         else if (m_level && fall[g*8 +: 8] != 8'h0 && nv[g*8 +: 8] == 8'h0) ni[g] = 1'b0;
         else if (!m_level && w && a == 4'h5 && m_cause[g*8 +: 8] != nc[g*8 +: 8]
                  && nc[g*8 +: 8] == 8'h0) ni[g] = 1'b0;
      end
      if (w) begin
         case (a)
            4'h0: m_dir = d;
            4'h1: m_pol = d;
            4'h6, 4'h7: m_mask = d;
            4'h8: m_level = d[10];
            default: ;
         endcase
      end
      m_val = nv;
      m_cause = nc;
      m_irq = ni;
   endtask

   task automatic do_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      model_step(1'b1, a, d);
      @(negedge clk);
      model_step(1'b0, 4'h0, 32'h0);
   endtask

   task automatic set_pins(input logic [31:0] p);
      @(negedge clk);
      pin_in = p;
      repeat (3) @(negedge clk);
      model_step(1'b0, 4'h0, 32'h0);
   endtask

   task automatic read_reg(input logic [3:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic read_check(input string req, input logic [3:0] a, input logic [31:0] exp);
      logic [31:0] v;
      read_reg(a, v);
      check(req, $sformatf("read 0x%0h", a), v, exp);
   endtask

   task automatic check_all();
      read_check("R2", 4'h0, m_dir);
      read_check("R4", 4'h1, m_pol);
      read_check("R4", 4'h2, m_val);
      read_check("R3", 4'h3, 32'h0);
      read_check("R3", 4'h4, 32'h0);
      read_check("R5", 4'h5, m_cause);
      read_check("R10", 4'h6, m_mask);
      read_check("R10", 4'h7, m_mask);
      read_check("R7", 4'h8, {21'h0, m_level, 10'h0});
      read_check("R7", 4'hF, 32'h0);
      check("R6", "grp_irq", {28'h0, grp_irq}, {28'h0, m_irq});
      check("R2", "pin_out", pin_out, m_val);
      check("R2", "pin_oe", pin_oe, m_dir);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired act=0x%08h exp=0x%08h", 32'h1, 32'h0);
      finish_run();
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", "pin_out after reset", pin_out, 32'h0);
      check("R1", "grp_irq after reset", {28'h0, grp_irq}, 32'h0);
      check_all();

      // R4: three-edge latency of an input pin
      @(negedge clk);
      reg_addr = 4'h2;
      pin_in = 32'h0010_0000;
      @(negedge clk); @(negedge clk);
      #1 check("R4", "value before third edge", reg_rdata, 32'h0);
      @(negedge clk);
      #1 check("R4", "value on third edge", reg_rdata, 32'h0010_0000);
      model_step(1'b0, 4'h0, 32'h0);
      read_check("R5", 4'h5, 32'h0010_0000);
      check("R6", "unmasked rise keeps summary low", {28'h0, grp_irq}, 32'h0);
      // R4: inversion of an idle input
      do_write(4'h1, 32'h0020_0000);
      read_check("R4", 4'h2, 32'h0030_0000);
      check_all();

      // R7: mode bit readback
      do_write(4'h8, 32'hFFFF_FFFF);
      read_check("R7", 4'h8, 32'h0000_0400);
      do_write(4'h8, 32'h0);
      read_check("R7", 4'h8, 32'h0);

      // R6: masked and unmasked rises
      do_write(4'h5, 32'h0);
      do_write(4'h6, 32'h00F0_0000);
      set_pins(32'h0050_0000);
      check("R6", "masked rise in group 2", {28'h0, grp_irq}, 32'h4);
      set_pins(32'h0250_0000);
      check("R6", "unmasked rise in group 3", {28'h0, grp_irq}, 32'h4);
      read_check("R5", 4'h5, 32'h0240_0000);

      // R9: edge mode release by cause write
      do_write(4'h5, 32'h0040_0000);
      check("R9", "untouched group keeps summary", {28'h0, grp_irq}, 32'h4);
      do_write(4'h5, 32'h0);
      check("R9", "cleared group drops summary", {28'h0, grp_irq}, 32'h0);
      check_all();

      // R8: level mode
      do_write(4'h8, 32'h0000_0400);
      set_pins(32'h02D0_0000);
      check("R8", "rise in level mode", {28'h0, grp_irq}, 32'h4);
      do_write(4'h5, 32'h0);
      check("R8", "cause write keeps level summary", {28'h0, grp_irq}, 32'h4);
      set_pins(32'h0250_0000);
      check("R8", "partial fall keeps summary", {28'h0, grp_irq}, 32'h4);
      set_pins(32'h0020_0000);
      check("R8", "group all zero drops summary", {28'h0, grp_irq}, 32'h0);
      check_all();

      // R2: value write limited to outputs
      do_write(4'h0, 32'h0000_FFFF);
      do_write(4'h2, 32'hFFFF_FFFF);
      read_check("R2", 4'h2, 32'h0000_FFFF);
      check("R2", "pin_oe", pin_oe, 32'h0000_FFFF);
      // R3: set and clear aliases
      do_write(4'h4, 32'h0000_00F0);
      read_check("R3", 4'h2, 32'h0000_FF0F);
      do_write(4'h3, 32'h00F0_0000);
      read_check("R3", 4'h2, 32'h0000_FF0F);
      read_check("R3", 4'h3, 32'h0);
      read_check("R3", 4'h4, 32'h0);

      // R10: mask alias
      do_write(4'h7, 32'hA5A5_A5A5);
      read_check("R10", 4'h6, 32'hA5A5_A5A5);
      check_all();

      // mixed random operations
      for (int n = 0; n < 250; n++) begin
         int op;
         op = int'($urandom % 4);
         if (op == 0) begin
            set_pins($urandom & $urandom);
         end else if (op == 1) begin
            set_pins($urandom | $urandom);
         end else begin
            logic [3:0] a;
            a = 4'($urandom % 10);
            do_write(a, $urandom);
         end
         check_all();
      end
      read_reg(4'h0, v);
      finish_run();
   end
endmodule